// File: doc/BRIEF.md
# Low-Power Entry Wakeup Guard

This block sits between the wakeup sources of a chip and its power-mode controller. When software begins moving the chip from run mode into a sleep or power-down state, it pulses a trigger. The block then opens a keep-out window of fixed length, timed by counting a reference clock of known frequency, so the window does not scale with the CPU clock. While the window is open, no wakeup reaches the power controller. A wakeup that shows up during the window is not dropped. It is held and presented once the window closes.

Every raw wakeup line first passes through a two-stage synchroniser. A small state machine with the states `WG_IDLE` and `WG_GUARD` times the window. It has four transitions: *launch* (`WG_IDLE` to `WG_GUARD` on the trigger), *restart* (a trigger in `WG_GUARD` clears the count), *tick* (`WG_GUARD` stays in `WG_GUARD` and counts up), and *expire* (`WG_GUARD` to `WG_IDLE` when the last count is reached). Held wakeup bits stay set until the power controller acknowledges them.

Top module: `wake_guard_top`

## Requirements
- R1: After reset, `busy` is 0, `wake_out` is all zeros, and no held wakeup bits remain.
- R2: The window length is WIN = ceil(`WINDOW_NS` × `REF_KHZ` / 1e6) reference cycles, which is 72 at the defaults. One trigger pulse sampled on a clock edge makes `busy` go high after that edge. `busy` then stays high for exactly WIN cycles.
- R3: If a trigger arrives while `busy` is high, the count restarts. `busy` then stays high for exactly WIN cycles after the edge that sampled the latest trigger, with no low cycle in between.
- R4: While `busy` is high, every bit of `wake_out` is 0, whatever `wake_raw` does.
- R5: A wakeup bit whose synchronised value is 1 in any cycle with `busy` high is held. After `busy` falls, that bit of `wake_out` is 1 even if the raw line has already returned to 0.
- R6: Outside the window, a raw wakeup is passed through with a latency of two clock edges. A bit that is not held follows the raw line back to 0 with the same latency.
- R7: A one-cycle `wake_ack` clears all held bits. If a bit is captured in the same cycle as the acknowledge, the capture takes priority and that bit stays held.
- R8: The wakeup lines are independent. Bit i of `wake_out` depends only on bit i of `wake_raw`, for every bit of the `NUM_WAKE`-bit vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_trig | input | 1 | Software pulse marking the start of low-power entry |
| wake_raw | input | NUM_WAKE | Unsynchronised wakeup requests |
| wake_ack | input | 1 | Clears the held wakeup bits |
| wake_out | output | NUM_WAKE | Gated wakeup requests sent to the power controller |
| busy | output | 1 | High for exactly the keep-out window |

## Verification
The hardest case to reach is the boundary where capture and release meet. One part of it is a wakeup that reaches the synchroniser output in the last guarded cycle, or while an acknowledge is pending. The other part is a retrigger that lands near the end of a window. Directed sequences place a wakeup inside the window, a retrigger 30 cycles into a window, and an acknowledge that coincides with a capture. A long random run then mixes sparse triggers, toggling wakeup lines and acknowledges. This scatters these events across every window phase, and a bench model predicts `wake_out` and `busy` cycle by cycle.

// File: rtl/wake_guard_pkg.sv
package wake_guard_pkg;

    typedef enum logic [0:0] {
        WG_IDLE  = 1'b0,
        WG_GUARD = 1'b1
    } wg_state_e;

    // Window length in reference cycles, rounded up.
    function automatic int wg_win_cycles(input int ref_khz, input int window_ns);
        return (ref_khz * window_ns + 999999) / 1000000;
    endfunction

endpackage

// File: rtl/wake_guard_sync.sv
module wake_guard_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic stage1_q;
        logic stage2_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= d_async[gi];
                stage2_q <= stage1_q;
            end
        end

        assign q_sync[gi] = stage2_q;
    end

endmodule

// File: rtl/wake_guard_window.sv
module wake_guard_window
    import wake_guard_pkg::*;
#(
    parameter int WIN_CYCLES = 72,
    parameter int CNT_W      = $clog2(WIN_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    output logic             guard_on,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

    wg_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: launch, restart, tick, expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WG_IDLE: begin
                if (trig) begin
                    state_d = WG_GUARD;
                    cnt_d   = '0;
                end
            end
            WG_GUARD: begin
                if (trig) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    state_d = WG_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = WG_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        guard_on = (state_q == WG_GUARD);
    end

endmodule

// File: rtl/wake_guard_hold.sv
module wake_guard_hold #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic [WIDTH-1:0] wake_sync,
    input  logic             ack,
    output logic [WIDTH-1:0] held_q
);

    logic [WIDTH-1:0] kept;
    logic [WIDTH-1:0] caught;

    always_comb begin
        kept   = ack ? '0 : held_q;
        caught = capture_en ? wake_sync : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= kept | caught;
    end

endmodule

// File: rtl/wake_guard_top.sv
module wake_guard_top
    import wake_guard_pkg::*;
#(
    parameter int NUM_WAKE  = 4,
    parameter int REF_KHZ   = 12000,
    parameter int WINDOW_NS = 6000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                entry_trig,
    input  logic [NUM_WAKE-1:0] wake_raw,
    input  logic                wake_ack,
    output logic [NUM_WAKE-1:0] wake_out,
    output logic                busy
);

    localparam int WIN_CYCLES = wg_win_cycles(REF_KHZ, WINDOW_NS);
    localparam int CNT_W      = $clog2(WIN_CYCLES + 1);

    logic [NUM_WAKE-1:0] sync_q;
    logic [NUM_WAKE-1:0] held_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                guard_on;

    wake_guard_sync #(.WIDTH(NUM_WAKE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (wake_raw),
        .q_sync  (sync_q)
    );

    wake_guard_window #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (entry_trig),
        .guard_on (guard_on),
        .cnt_q    (cnt_q)
    );

    wake_guard_hold #(.WIDTH(NUM_WAKE)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (guard_on),
        .wake_sync  (sync_q),
        .ack        (wake_ack),
        .held_q     (held_q)
    );

    always_comb begin
        busy     = guard_on;
        wake_out = guard_on ? '0 : (sync_q | held_q);
    end

endmodule

// File: rtl/wake_guard_chk.sv
module wake_guard_chk #(
    parameter int NUM_WAKE   = 4,
    parameter int WIN_CYCLES = 72,
    parameter int CNT_W      = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                entry_trig,
    input logic                wake_ack,
    input logic                busy,
    input logic [NUM_WAKE-1:0] wake_out,
    input logic [NUM_WAKE-1:0] sync_q,
    input logic [NUM_WAKE-1:0] held_q,
    input logic [CNT_W-1:0]    cnt_q
);

    a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (wake_out == '0));

    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        entry_trig |=> (busy && (cnt_q == '0)));

    a_r2_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (int'($past(cnt_q)) == WIN_CYCLES - 1));

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((held_q & $past(sync_q)) == $past(sync_q)));

    a_r7_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_ack && !busy) |=> (held_q == '0));

endmodule

bind wake_guard_top wake_guard_chk #(
    .NUM_WAKE   (NUM_WAKE),
    .WIN_CYCLES (WIN_CYCLES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_trig (entry_trig),
    .wake_ack   (wake_ack),
    .busy       (busy),
    .wake_out   (wake_out),
    .sync_q     (sync_q),
    .held_q     (held_q),
    .cnt_q      (cnt_q)
);

// File: tb/wake_guard_top_test.sv
module wake_guard_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 4;
    localparam int REF_KHZ    = 12000;
    localparam int WIN_NS     = 6000;
    localparam int WIN        = (REF_KHZ * WIN_NS + 999999) / 1000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          entry_trig = 1'b0;
    logic [NW-1:0] wake_raw = '0;
    logic          wake_ack = 1'b0;
    logic [NW-1:0] wake_out;
    logic          busy;

    wake_guard_top #(.NUM_WAKE(NW), .REF_KHZ(REF_KHZ), .WINDOW_NS(WIN_NS)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_trig (entry_trig),
        .wake_raw   (wake_raw),
        .wake_ack   (wake_ack),
        .wake_out   (wake_out),
        .busy       (busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model state
    logic [NW-1:0] m_s1 = '0, m_s2 = '0, m_held = '0;
    bit            m_busy = 1'b0;
    int            m_cnt = 0;
    logic          obs_busy;
    logic [NW-1:0] obs_out;

    function automatic logic [NW-1:0] model_out();
        return m_busy ? '0 : (m_s2 | m_held);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic [NW-1:0] r, input logic a);
        logic [NW-1:0] nh;
        @(negedge clk);
        obs_busy = busy;
        obs_out  = wake_out;
        chk(m_busy ? "R4" : "R8", 32'(wake_out), 32'(model_out()));
        chk("R2", 32'(busy), 32'(m_busy));
        entry_trig = t;
        wake_raw   = r;
        wake_ack   = a;
        nh = (a ? '0 : m_held) | (m_busy ? m_s2 : '0);
        if (t) begin
            m_busy = 1'b1;
            m_cnt  = 0;
        end else if (m_busy) begin
            if (m_cnt == WIN - 1) m_busy = 1'b0;
            else                  m_cnt++;
        end
        m_held = nh;
        m_s2   = m_s1;
        m_s1   = r;
    endtask

    task automatic run_out(output int len);
        len = 0;
        do begin
            step(1'b0, wake_raw, 1'b0);
            if (obs_busy) len++;
        end while (obs_busy);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int len;
        int seed;
        logic [NW-1:0] r;
        seed = 32'h5eed_0042;
        void'($urandom(seed));

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", 32'(busy), 32'd0);
        chk("R1", 32'(wake_out), 32'd0);
        rst_n = 1'b1;

        // R2: single trigger, window length
        step(1'b1, '0, 1'b0);
        run_out(len);
        chk("R2", len, WIN);

        // R5: wakeup inside window is held and replayed
        step(1'b1, '0, 1'b0);
        repeat (5) step(1'b0, '0, 1'b0);
        repeat (3) step(1'b0, 4'b0101, 1'b0);
        step(1'b0, '0, 1'b0);
        run_out(len);
        step(1'b0, '0, 1'b0);
        chk("R5", 32'(obs_out), 32'h5);
        // R7: acknowledge clears held bits
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b0);
        chk("R7", 32'(obs_out), 32'h0);

        // R3: retrigger 30 cycles into window
        step(1'b1, '0, 1'b0);
        repeat (30) step(1'b0, '0, 1'b0);
        chk("R3", 32'(obs_busy), 32'd1);
        step(1'b1, '0, 1'b0);
        run_out(len);
        chk("R3", len, WIN);

        // R6: pass-through latency of two edges when idle
        step(1'b0, 4'b1000, 1'b0);
        step(1'b0, 4'b1000, 1'b0);
        chk("R6", 32'(obs_out), 32'h0);
        step(1'b0, '0, 1'b0);
        chk("R6", 32'(obs_out), 32'h8);
        step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b0);
        chk("R6", 32'(obs_out), 32'h0);

        // R7: capture in the same cycle as acknowledge wins
        step(1'b1, 4'b0010, 1'b0);
        repeat (4) step(1'b0, 4'b0010, 1'b0);
        step(1'b0, 4'b0010, 1'b1);
        step(1'b0, '0, 1'b0);
        run_out(len);
        step(1'b0, '0, 1'b0);
        chk("R7", 32'(obs_out), 32'h2);
        step(1'b0, '0, 1'b1);

        // R8: random mix checked against the model each cycle
        r = '0;
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 8) == 0) r = r ^ NW'($urandom);
            step(($urandom % 64) == 0, r, ($urandom % 16) == 0);
        end
        for (int i = 0; i < WIN + 4; i++) step(1'b0, '0, 1'b1);
        chk("R8", 32'(obs_out), 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule